// File: doc/BRIEF.md
# UART Serial Transmitter with Baud Divider

This block turns characters handed over by a host into asynchronous serial frames on a single output line. A divider chain derives a timing tick from the system clock. One tick occurs every N clock cycles, and N is selected by a 4-bit rate code. Every serial bit lasts sixteen of these ticks. The host writes one character at a time into a single-entry holding buffer. The shifter takes the character from that buffer when the line is free, builds the frame and clocks it out.

A frame begins with a low start bit. The character follows, least significant bit first, as either 7 or 8 bits. When parity is switched on, the parity bit comes next. The block does not compute this bit: it sends the value the host wrote alongside the character. A high stop bit ends the frame. An optional infrared mode replaces level coding with short pulses. An active-low shutdown input stops everything on the next clock edge, even partway through a frame.

A buffer-empty flag tells the host when it may write again. The same flag, gated by an enable input, drives an active-low interrupt line.

Top module: `uart_tx_core`

## Requirements
- R1: While reset is held and after it is released, `tx` is high (level-coded idle) and `buf_empty` is 1.
- R2: The rate code `baud_sel` selects the divisor from this table: codes 0–7 give 1, 2, 4, 8, 16, 32, 64, 128, and codes 8–15 give 3, 6, 12, 24, 48, 96, 192, 384. Each bit on `tx` lasts exactly 16 × divisor clock cycles, and line transitions occur only on divider ticks.
- R3: With `short_char`=0 and `par_en`=0, a frame is 0 (start), then `wr_data[0]` through `wr_data[7]` in that order, then 1 (stop).
- R4: With `short_char`=1, only `wr_data[6:0]` is sent, LSB first. `wr_data[7]` never appears on the line.
- R5: With `par_en`=1, one extra bit equal to the `wr_par` value written with the character is sent between the last data bit and the stop bit.
- R6: The line rests high between frames in level-coded mode. If a character is waiting when a stop bit ends, the next start bit begins in the very next bit slot, with no gap.
- R7: A write (`wr_valid`=1 while `buf_empty`=1) clears `buf_empty` on the next cycle. `buf_empty` returns to 1 on the edge where the character enters the shifter, which is the same edge on which its start bit begins. A write made while `buf_empty`=0 is dropped.
- R8: With `irda_en`=1, each 0 bit of the frame (the start bit included) is sent as a high pulse 3 ticks wide at the beginning of its bit slot. The line is low at all other times, including while idle.
- R9: While `shdn_n`=0, from the next cycle on, `tx` sits at its idle level (high when level-coded, low in infrared mode), the holding buffer is empty, and writes are dropped. No frame resumes after `shdn_n` returns to 1.
- R10: `irq_n` is 0 exactly when `buf_empty`=1 and `irq_en`=1. Otherwise it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shdn_n | input | 1 | Active-low shutdown; halts the transmitter at once |
| baud_sel | input | 4 | Rate code selecting the clock divisor |
| short_char | input | 1 | 1 = 7-bit characters, 0 = 8-bit |
| par_en | input | 1 | 1 = append host-supplied parity bit |
| irda_en | input | 1 | 1 = infrared short-pulse coding |
| irq_en | input | 1 | Mask enable for the buffer-empty interrupt |
| wr_valid | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Character to send |
| wr_par | input | 1 | Parity value to send with the character |
| tx | output | 1 | Serial data line |
| buf_empty | output | 1 | Holding buffer is free |
| irq_n | output | 1 | Active-low buffer-empty interrupt |

## Verification
The properties take for granted that `irda_en` is left alone while a frame is on the line, because the idle level and the pulse coding both depend on it. They also assume that a change of mode is not itself a transition to be timed against the divider tick. The stimulus changes the rate code, character width, parity and mode only after the scoreboard has drained and a further full bit slot has passed. It raises shutdown only between clock edges. Writes are strobed for a single cycle, and a write into a full buffer is issued deliberately, in a test of its own.

// File: rtl/uart_tx_pkg.sv
// Package: shared constants and types for the serial transmitter.
// Assumes: a 16x oversampled bit slot and a 3-tick infrared pulse.
package uart_tx_pkg;
    localparam int OVS         = 16;  // ticks per serial bit
    localparam int IRDA_TICKS  = 3;   // width of an infrared pulse in ticks
    localparam int FRAME_EXTRA = 3;   // start + parity + stop around the data

    typedef enum logic {
        SH_IDLE = 1'b0,
        SH_RUN  = 1'b1
    } sh_state_t;
endpackage

// File: rtl/uart_baud_gen.sv
// Module: rate divider. Emits a one-cycle tick every N clocks, where N is
// (1 or 3) shifted left by the low bits of the rate code.
// Assumes: the rate code may change at any time; the counter recovers by
// comparing with >= so a smaller divisor never causes a wrap-around wait.
module uart_baud_gen #(
    parameter int SEL_BITS = 4,
    parameter int CNT_BITS = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic [SEL_BITS-1:0] sel,
    output logic                tick
);
    logic [CNT_BITS-1:0] cnt_q;
    logic [CNT_BITS-1:0] base_w;
    logic [CNT_BITS-1:0] lim_w;

    // Decode the rate code into the terminal count (divisor minus one).
    always_comb begin
        base_w = sel[SEL_BITS-1] ? CNT_BITS'(3) : CNT_BITS'(1);
        lim_w  = (base_w << sel[SEL_BITS-2:0]) - CNT_BITS'(1);
    end

    // Tick when the count reaches its limit; held off while stopped.
    always_comb tick = run && (cnt_q >= lim_w);

    // Advance the divider, restarting at every tick and while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_BITS'(1);
        end
    end
endmodule

// File: rtl/uart_tx_hold.sv
// Module: single-entry holding buffer between host and shifter.
// Assumes: the shifter only takes when full, so write and take never
// meet in one cycle; writes into a full buffer are dropped.
module uart_tx_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_par,
    input  logic          take,
    output logic          full,
    output logic [DW-1:0] data,
    output logic          par
);
    // Occupancy flag: set on an accepted write, cleared on take or stop.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            full <= 1'b0;
        end else if (take) begin
            full <= 1'b0;
        end else if (wr_en && !full) begin
            full <= 1'b1;
        end
    end

    // Payload capture: only an accepted write updates the stored character.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data <= '0;
            par  <= 1'b0;
        end else if (run && wr_en && !full) begin
            data <= wr_data;
            par  <= wr_par;
        end
    end
endmodule

// File: rtl/uart_tx_framer.sv
// Module: builds the bit sequence of one frame, bit 0 first on the line:
// start, data LSB first (DW or DW-1 bits), optional parity, stop; unused
// upper positions are filled with ones. Also reports the last bit index.
// Assumes: purely combinational; sampled by the shifter at load time.
module uart_tx_framer #(
    parameter int DW = 8,
    parameter int FW = DW + 3,
    parameter int CW = 4
) (
    input  logic [DW-1:0] data,
    input  logic          par,
    input  logic          short_char,
    input  logic          par_en,
    output logic [FW-1:0] frame,
    output logic [CW-1:0] last_idx
);
    // Place start, data and parity bits; everything else stays high.
    always_comb begin
        frame    = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < DW - 1; i++) begin
            frame[i+1] = data[i];
        end
        if (!short_char) begin
            frame[DW] = data[DW-1];
        end
        if (par_en) begin
            if (short_char) begin
                frame[DW] = par;
            end else begin
                frame[DW+1] = par;
            end
        end
    end

    // Index of the stop bit: start + data + parity positions before it.
    always_comb begin
        last_idx = short_char ? CW'(DW) : CW'(DW + 1);
        if (par_en) begin
            last_idx = last_idx + CW'(1);
        end
    end
endmodule

// File: rtl/uart_tx_shifter.sv
// Module: frame shifter. Loads a built frame on a tick when the line is
// free (or when the stop bit of the current frame ends), then holds each
// bit for OVS ticks. Drives the line in level or infrared pulse coding.
// Assumes: tick is a single-cycle strobe; run low clears all state.
module uart_tx_shifter
    import uart_tx_pkg::*;
#(
    parameter int FW    = 11,
    parameter int CW    = 4,
    parameter int OVS_N = OVS,
    parameter int PULSE = IRDA_TICKS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          tick,
    input  logic          hold_full,
    input  logic [FW-1:0] frame_in,
    input  logic [CW-1:0] last_in,
    input  logic          irda_in,
    output logic          take,
    output logic          tx
);
    localparam int OW = $clog2(OVS_N);

    sh_state_t      state_q;
    logic [FW-1:0]  sreg_q;
    logic [CW-1:0]  left_q;
    logic [OW-1:0]  sub_q;
    logic           irda_q;
    logic           end_bit;
    logic           frame_done;

    // Bit-slot and frame boundaries, both aligned to a tick.
    always_comb begin
        end_bit    = (state_q == SH_RUN) && tick && (sub_q == OW'(OVS_N - 1));
        frame_done = end_bit && (left_q == '0);
        take       = run && tick && hold_full && ((state_q == SH_IDLE) || frame_done);
    end

    // Frame sequencing: load, count ticks, shift at slot end, retire.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            state_q <= SH_IDLE;
            sreg_q  <= '1;
            left_q  <= '0;
            sub_q   <= '0;
            irda_q  <= 1'b0;
        end else if (take) begin
            state_q <= SH_RUN;
            sreg_q  <= frame_in;
            left_q  <= last_in;
            sub_q   <= '0;
            irda_q  <= irda_in;
        end else if (frame_done) begin
            state_q <= SH_IDLE;
            sreg_q  <= '1;
            sub_q   <= '0;
        end else if (end_bit) begin
            sreg_q  <= {1'b1, sreg_q[FW-1:1]};
            left_q  <= left_q - CW'(1);
            sub_q   <= '0;
        end else if ((state_q == SH_RUN) && tick) begin
            sub_q   <= sub_q + OW'(1);
        end
    end

    // Line coding: idle level follows the live mode; a frame uses its own.
    always_comb begin
        if (state_q == SH_IDLE) begin
            tx = !irda_in;
        end else if (irda_q) begin
            tx = !sreg_q[0] && (sub_q < OW'(PULSE));
        end else begin
            tx = sreg_q[0];
        end
    end
endmodule

// File: rtl/uart_tx_core.sv
// Module: top of the serial transmitter. Connects the rate divider, the
// holding buffer, the frame builder and the shifter, and forms the
// masked buffer-empty interrupt.
// Assumes: mode inputs are stable while a frame is on the line; the rate
// code is read live, width/parity/mode are captured at frame load.
module uart_tx_core
    import uart_tx_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int SEL_BITS  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shdn_n,
    input  logic [SEL_BITS-1:0]  baud_sel,
    input  logic                 short_char,
    input  logic                 par_en,
    input  logic                 irda_en,
    input  logic                 irq_en,
    input  logic                 wr_valid,
    input  logic [DATA_BITS-1:0] wr_data,
    input  logic                 wr_par,
    output logic                 tx,
    output logic                 buf_empty,
    output logic                 irq_n
);
    localparam int MAX_DIV  = 3 * (1 << ((1 << (SEL_BITS - 1)) - 1));
    localparam int CNT_BITS = $clog2(MAX_DIV + 1);
    localparam int FW       = DATA_BITS + FRAME_EXTRA;
    localparam int CW       = $clog2(FW);

    logic                 baud_tick;
    logic                 take;
    logic                 hold_full;
    logic [DATA_BITS-1:0] hold_data;
    logic                 hold_par;
    logic [FW-1:0]        frame;
    logic [CW-1:0]        last_idx;

    uart_baud_gen #(
        .SEL_BITS (SEL_BITS),
        .CNT_BITS (CNT_BITS)
    ) baud_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (shdn_n),
        .sel   (baud_sel),
        .tick  (baud_tick)
    );

    uart_tx_hold #(
        .DW (DATA_BITS)
    ) hold_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (shdn_n),
        .wr_en   (wr_valid),
        .wr_data (wr_data),
        .wr_par  (wr_par),
        .take    (take),
        .full    (hold_full),
        .data    (hold_data),
        .par     (hold_par)
    );

    uart_tx_framer #(
        .DW (DATA_BITS),
        .FW (FW),
        .CW (CW)
    ) framer_i (
        .data       (hold_data),
        .par        (hold_par),
        .short_char (short_char),
        .par_en     (par_en),
        .frame      (frame),
        .last_idx   (last_idx)
    );

    uart_tx_shifter #(
        .FW    (FW),
        .CW    (CW),
        .OVS_N (OVS),
        .PULSE (IRDA_TICKS)
    ) shift_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (shdn_n),
        .tick      (baud_tick),
        .hold_full (hold_full),
        .frame_in  (frame),
        .last_in   (last_idx),
        .irda_in   (irda_en),
        .take      (take),
        .tx        (tx)
    );

    // Host-facing status: free buffer and its masked interrupt.
    always_comb begin
        buf_empty = !hold_full;
        irq_n     = !(buf_empty && irq_en);
    end
endmodule

// File: rtl/uart_tx_core_chk.sv
// Module: property checker for uart_tx_core, attached with bind below.
// Assumes: irda_en only changes while the line is idle.
module uart_tx_core_chk (
    input logic clk,
    input logic rst_n,
    input logic shdn_n,
    input logic irda_en,
    input logic irq_en,
    input logic wr_valid,
    input logic tx,
    input logic buf_empty,
    input logic irq_n,
    input logic tick
);
    // R7: an accepted write occupies the buffer on the next cycle.
    a_r7_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && buf_empty && shdn_n) |=> !buf_empty)
        else $error("a_r7_write_fills");

    // R7: outside reset and shutdown the buffer only frees on a tick.
    a_r7_free_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(buf_empty) && $past(shdn_n) && $past(rst_n)) |-> $past(tick))
        else $error("a_r7_free_on_tick");

    // R9: shutdown leaves an empty buffer and an idle line next cycle.
    a_r9_shdn_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!shdn_n) |=> (buf_empty && (tx != irda_en)))
        else $error("a_r9_shdn_idle");

    // R10: a masked interrupt is never asserted.
    a_r10_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en) |-> irq_n)
        else $error("a_r10_irq_masked");

    // R2: in level coding the line only falls on a divider tick.
    a_r2_fall_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(tx) && !irda_en && !$past(irda_en) && $past(shdn_n) && $past(rst_n))
        |-> $past(tick))
        else $error("a_r2_fall_on_tick");
endmodule

bind uart_tx_core uart_tx_core_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .shdn_n    (shdn_n),
    .irda_en   (irda_en),
    .irq_en    (irq_en),
    .wr_valid  (wr_valid),
    .tx        (tx),
    .buf_empty (buf_empty),
    .irq_n     (irq_n),
    .tick      (baud_tick)
);

// File: tb/uart_tx_core_tb_top.sv
// Scoreboard bench: the driver queues the expected frames, the monitor
// decodes the line and compares bit by bit at mid-slot sample points.
module uart_tx_core_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       shdn_n = 1'b1;
    logic [3:0] baud_sel = 4'd0;
    logic       short_char = 1'b0;
    logic       par_en = 1'b0;
    logic       irda_en = 1'b0;
    logic       irq_en = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wr_par = 1'b0;
    logic       tx;
    logic       buf_empty;
    logic       irq_n;

    always #5 clk = ~clk;

    uart_tx_core dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .shdn_n     (shdn_n),
        .baud_sel   (baud_sel),
        .short_char (short_char),
        .par_en     (par_en),
        .irda_en    (irda_en),
        .irq_en     (irq_en),
        .wr_valid   (wr_valid),
        .wr_data    (wr_data),
        .wr_par     (wr_par),
        .tx         (tx),
        .buf_empty  (buf_empty),
        .irq_n      (irq_n)
    );

    typedef struct {
        logic [10:0] bits;
        int          nb;
        int          par_pos;
        bit          irda;
        bit          short7;
        int          div;
        bit          b2b;
    } exp_t;

    exp_t   exp_q[$];
    int     n_vec = 0;
    int     n_bad = 0;
    longint cyc = 0;
    longint last_end = 0;
    bit     mon_on = 1'b1;
    bit     mon_busy = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string what, input longint act, input longint expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", what, act, expv);
        end
    endtask

    function automatic int bdiv(input logic [3:0] s);
        case (s)
            4'd0: return 1;    4'd1: return 2;    4'd2: return 4;    4'd3: return 8;
            4'd4: return 16;   4'd5: return 32;   4'd6: return 64;   4'd7: return 128;
            4'd8: return 3;    4'd9: return 6;    4'd10: return 12;  4'd11: return 24;
            4'd12: return 48;  4'd13: return 96;  4'd14: return 192; default: return 384;
        endcase
    endfunction

    function automatic exp_t mk(input logic [7:0] d, input logic p, input bit b2b);
        exp_t e;
        int   n;
        int   k;
        e.bits    = '1;
        e.bits[0] = 1'b0;
        n = short_char ? 7 : 8;
        for (int i = 0; i < n; i++) e.bits[1+i] = d[i];
        k = 1 + n;
        e.par_pos = -1;
        if (par_en) begin
            e.bits[k] = p;
            e.par_pos = k;
            k++;
        end
        e.bits[k] = 1'b1;
        e.nb      = k + 1;
        e.irda    = irda_en;
        e.short7  = short_char;
        e.div     = bdiv(baud_sel);
        e.b2b     = b2b;
        return e;
    endfunction

    task automatic raw_write(input logic [7:0] d, input logic p);
        wr_data  = d;
        wr_par   = p;
        wr_valid = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic send(input logic [7:0] d, input logic p, input bit b2b);
        while (!buf_empty) @(negedge clk);
        exp_q.push_back(mk(d, p, b2b));
        raw_write(d, p);
        chk(buf_empty == 1'b0, "R7 write occupies buffer", buf_empty, 0);
    endtask

    task automatic wait_idle();
        while (exp_q.size() != 0 || mon_busy) @(negedge clk);
        repeat (16 * bdiv(baud_sel) + 4) @(negedge clk);
    endtask

    task automatic wait_to(inout longint off, input longint tgt);
        while (off < tgt) begin
            @(negedge clk);
            off++;
        end
    endtask

    // Monitor: pops the oldest expected frame when its start appears.
    initial begin : monitor
        exp_t   it;
        longint t0;
        longint off;
        longint d;
        string  rq;
        forever begin
            @(negedge clk);
            if (mon_on && exp_q.size() != 0 && (tx == exp_q[0].irda)) begin
                it = exp_q.pop_front();
                mon_busy = 1'b1;
                t0  = cyc;
                off = 0;
                d   = it.div;
                if (it.b2b) chk(t0 == last_end, "R6 next start without gap", t0, last_end);
                for (int k = 0; k < it.nb; k++) begin
                    if (it.irda) begin
                        wait_to(off, k * 16 * d + d);
                        chk(tx == !it.bits[k], $sformatf("R8 pulse bit %0d", k), tx, !it.bits[k]);
                        if (k == 0) begin
                            wait_to(off, 3 * d);
                            chk(tx == 1'b0, "R8 pulse width 3 ticks", tx, 0);
                        end
                        wait_to(off, k * 16 * d + 8 * d);
                        chk(tx == 1'b0, $sformatf("R8 low mid-slot bit %0d", k), tx, 0);
                    end else begin
                        if (k == it.nb - 1) rq = "R6 stop";
                        else if (k == it.par_pos) rq = "R5 parity";
                        else if (it.short7) rq = "R4 data";
                        else rq = "R3 data";
                        wait_to(off, k * 16 * d + 8 * d);
                        chk(tx == it.bits[k], $sformatf("%s bit %0d", rq, k), tx, it.bits[k]);
                        if (k == 0) begin
                            wait_to(off, 16 * d - 1);
                            chk(tx == 1'b0, "R2 start bit still low at slot end", tx, 0);
                            wait_to(off, 16 * d);
                            chk(tx == it.bits[1], "R2 first data bit at 16 ticks", tx, it.bits[1]);
                        end
                    end
                end
                last_end = t0 + it.nb * 16 * d;
                mon_busy = 1'b0;
            end
        end
    end

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 190000);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : driver
        int lows;
        repeat (3) @(negedge clk);
        chk(tx == 1'b1, "R1 tx high in reset", tx, 1);
        chk(buf_empty == 1'b1, "R1 empty in reset", buf_empty, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx == 1'b1, "R1 tx high after reset", tx, 1);
        chk(buf_empty == 1'b1, "R1 empty after reset", buf_empty, 1);
        chk(irq_n == 1'b1, "R10 masked irq idle", irq_n, 1);
        irq_en = 1'b1;
        @(negedge clk);
        chk(irq_n == 1'b0, "R10 irq on empty", irq_n, 0);

        // 8-bit, no parity, divisor 1, with back-to-back frames.
        baud_sel = 4'd0;
        send(8'h55, 1'b0, 1'b0);
        send(8'hA3, 1'b0, 1'b1);
        send(8'h00, 1'b0, 1'b1);
        send(8'hFF, 1'b0, 1'b1);
        wait_idle();

        // 8-bit with host parity, divisor 8.
        baud_sel = 4'd3; par_en = 1'b1;
        repeat (4) @(negedge clk);
        send(8'h3C, 1'b1, 1'b0);
        send(8'hC5, 1'b0, 1'b1);
        wait_idle();

        // 7-bit, no parity, divisor 3; bit 7 must not appear.
        baud_sel = 4'd8; par_en = 1'b0; short_char = 1'b1;
        repeat (4) @(negedge clk);
        send(8'hD5, 1'b0, 1'b0);
        send(8'h80, 1'b1, 1'b1);
        wait_idle();

        // 7-bit with parity, divisor 6.
        baud_sel = 4'd9; par_en = 1'b1;
        repeat (4) @(negedge clk);
        send(8'h2A, 1'b0, 1'b0);
        send(8'h15, 1'b1, 1'b1);
        wait_idle();

        // Largest divisor, 7-bit no parity; empty flag rises with the start.
        baud_sel = 4'd15; par_en = 1'b0;
        repeat (4) @(negedge clk);
        send(8'h4B, 1'b0, 1'b0);
        while (!buf_empty) @(negedge clk);
        chk(tx == 1'b0, "R7 empty set as start bit begins", tx, 0);
        wait_idle();

        // Infrared coding, 8-bit with parity, divisor 2.
        baud_sel = 4'd1; short_char = 1'b0; par_en = 1'b1; irda_en = 1'b1;
        repeat (40) @(negedge clk);
        chk(tx == 1'b0, "R8 idle low", tx, 0);
        send(8'h5A, 1'b1, 1'b0);
        send(8'h0F, 1'b0, 1'b1);
        wait_idle();
        irda_en = 1'b0; par_en = 1'b0; baud_sel = 4'd0;
        repeat (40) @(negedge clk);

        // A write into a full buffer is dropped.
        send(8'h81, 1'b0, 1'b0);
        send(8'h42, 1'b0, 1'b1);
        chk(irq_n == 1'b1, "R10 irq off while full", irq_n, 1);
        raw_write(8'hE7, 1'b1);
        chk(buf_empty == 1'b0, "R7 still full after dropped write", buf_empty, 0);
        wait_idle();
        lows = 0;
        repeat (300) begin @(negedge clk); if (tx == 1'b0) lows++; end
        chk(lows == 0, "R7 dropped write never sent", lows, 0);
        chk(irq_n == 1'b0, "R10 irq back on empty", irq_n, 0);
        irq_en = 1'b0;
        @(negedge clk);
        chk(irq_n == 1'b1, "R10 irq masked while empty", irq_n, 1);

        // Shutdown in mid-frame, level coding.
        mon_on = 1'b0;
        baud_sel = 4'd1;
        raw_write(8'h00, 1'b0);
        while (tx == 1'b1) @(negedge clk);
        repeat (40) @(negedge clk);
        raw_write(8'h00, 1'b0);
        chk(buf_empty == 1'b0, "R9 buffer full before shutdown", buf_empty, 0);
        chk(tx == 1'b0, "R9 frame in progress", tx, 0);
        shdn_n = 1'b0;
        @(negedge clk);
        chk(tx == 1'b1, "R9 line idle at once", tx, 1);
        chk(buf_empty == 1'b1, "R9 buffer cleared", buf_empty, 1);
        raw_write(8'h00, 1'b0);
        chk(buf_empty == 1'b1, "R9 write ignored in shutdown", buf_empty, 1);
        repeat (10) @(negedge clk);
        shdn_n = 1'b1;
        lows = 0;
        repeat (800) begin @(negedge clk); if (tx == 1'b0) lows++; end
        chk(lows == 0, "R9 no frame resumes", lows, 0);
        chk(buf_empty == 1'b1, "R9 buffer stays empty", buf_empty, 1);

        // Shutdown in mid-frame, infrared coding.
        irda_en = 1'b1;
        @(negedge clk);
        raw_write(8'h00, 1'b0);
        while (tx == 1'b0) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(tx == 1'b1, "R8 pulse in progress", tx, 1);
        shdn_n = 1'b0;
        @(negedge clk);
        chk(tx == 1'b0, "R9 infrared line idle low", tx, 0);
        shdn_n = 1'b1;
        lows = 0;
        repeat (400) begin @(negedge clk); if (tx == 1'b1) lows++; end
        chk(lows == 0, "R9 no infrared pulse after shutdown", lows, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule